// File: doc/BRIEF.md
# Polled Keyboard and Character Display Register Window

This block is the processor-side register window for one keyboard receiver and one character display on a 16-bit memory-mapped bus. Four device registers sit at fixed addresses: keyboard status, keyboard data, display status and display data. Software polls a ready flag in bit 15 of each status register. When the keyboard flag is set, software reads the received character. When the display flag is set, software writes the next character.

The block decodes every bus address. Read data is steered from the addressed device register, or from memory when no device register matches. A separate select output tells the memory not to respond to device addresses.

Handshakes hang off the ready flags. A held keyboard character blocks any new arrival until software reads the data register. A display write clears the display flag and emits a one-cycle load pulse. The display-done input raises the flag again. Display writes made while the display is busy are dropped.

Top module: `char_io_regfile`

## Requirements
- R1: Addresses 0xFE00, 0xFE02, 0xFE04 and 0xFE06 are device registers. For them `mem_sel` is 0. For every other address `mem_sel` is 1 and `rd_data` equals `mem_rdata`, combinationally in the same cycle.
- R2: A read at 0xFE02 (keyboard data) returns the held character in bits 7:0 and zero in bits 15:8.
- R3: When `rx_valid` is high at a clock edge while the keyboard flag is 0, `rx_char` is captured. The flag (bit 15 of 0xFE00) reads 1 from the next cycle.
- R4: While the keyboard flag is 1, an arriving character is discarded and the held character is kept.
- R5: A cycle with `rd_en` high at 0xFE02 clears the keyboard flag at the next edge. If a character arrives in that same cycle while the flag is already 0, the character is accepted and the flag is set.
- R6: After reset, the display flag (bit 15 of 0xFE04) is 1 and the keyboard flag is 0. The display flag reads 1 whenever the display can take a character.
- R7: A write to 0xFE06 while the display flag is 1 has three effects in the next cycle: `disp_load` is high for exactly one cycle, `disp_char` holds `wr_data[7:0]`, and the display flag reads 0.
- R8: A write to 0xFE06 while the display flag is 0 is ignored. No load pulse follows, `disp_char` keeps its value and the flag stays 0.
- R9: A `disp_done` pulse while the display flag is 0 sets the flag from the next cycle. This also holds in a cycle with an ignored display write.
- R10: Bits 14:0 of both status registers read 0, and 0xFE06 reads as 0. Writes to 0xFE00, 0xFE02 and 0xFE04 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Bus address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| mem_rdata | input | 16 | Read data from memory |
| rd_data | output | 16 | Read data returned to the processor |
| mem_sel | output | 1 | High when memory should serve this address |
| rx_valid | input | 1 | Received-character strobe |
| rx_char | input | 8 | Received character |
| disp_done | input | 1 | Display finished the last character |
| disp_load | output | 1 | One-cycle load pulse to the display |
| disp_char | output | 8 | Character for the display |

## Verification
Several properties are checked by assertions on every cycle:
- memory data passes through on non-device addresses;
- a held keyboard character survives a further arrival;
- an accepted arrival is captured;
- a load pulse always coincides with a busy display flag;
- a busy display never produces a load.

The bench's scenarios cover the rest:
- collisions in a single cycle: a read and an arrival together, or a done pulse and an ignored write together;
- status writes having no effect, which is only visible by reading the registers back;
- the reset values.

A behavioural model compares every output each cycle, under directed and random traffic.

// File: rtl/char_io_pkg.sv
// Package: shared types for the keyboard/display register window.
// Assumes a single clock domain and a synchronous active-low reset.
package char_io_pkg;

    // Which device register, if any, the current address selects
    typedef enum logic [2:0] {
        REG_NONE  = 3'd0,
        REG_KSTAT = 3'd1,
        REG_KDATA = 3'd2,
        REG_DSTAT = 3'd3,
        REG_DDATA = 3'd4
    } cio_reg_e;

endpackage

// File: rtl/cio_addr_decode.sv
// Module: address decoder for the register window.
// Compares the full bus address against the four device addresses and
// reports which register is hit. Memory is deselected on any hit.
// Assumes the addresses given are distinct.
module cio_addr_decode
    import char_io_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] KSTAT_A = 16'hFE00,
    parameter logic [ADDR_W-1:0] KDATA_A = 16'hFE02,
    parameter logic [ADDR_W-1:0] DSTAT_A = 16'hFE04,
    parameter logic [ADDR_W-1:0] DDATA_A = 16'hFE06
) (
    input  logic [ADDR_W-1:0] addr,
    output cio_reg_e          reg_sel,
    output logic              mem_sel
);

    localparam int N_REGS = 4;
    localparam logic [N_REGS*ADDR_W-1:0] ADDR_LIST = {DDATA_A, DSTAT_A, KDATA_A, KSTAT_A};

    logic [N_REGS-1:0] hit;

    // One comparator per device register
    for (genvar g = 0; g < N_REGS; g++) begin : g_cmp
        assign hit[g] = (addr == ADDR_LIST[g*ADDR_W +: ADDR_W]);
    end

    // Turn the hit vector into a register selector
    always_comb begin
        reg_sel = REG_NONE;
        if (hit[0])      reg_sel = REG_KSTAT;
        else if (hit[1]) reg_sel = REG_KDATA;
        else if (hit[2]) reg_sel = REG_DSTAT;
        else if (hit[3]) reg_sel = REG_DDATA;
    end

    // Memory answers only when no device register is addressed
    assign mem_sel = ~(|hit);

    // R1: distinct addresses can never hit together
    always_comb begin
        p_single_hit_r1: assert ($onehot0(hit));
    end

endmodule

// File: rtl/cio_kbd_port.sv
// Module: keyboard receive holding register with ready flag.
// Captures a character only while the flag is low. The flag is set on
// capture and cleared by a processor read of the data register.
// Assumes rx_valid is a one-cycle strobe per received character.
module cio_kbd_port #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              data_read,
    output logic              ready,
    output logic [CHAR_W-1:0] char_q
);

    logic accept;

    // An arrival is taken only while no character is waiting
    assign accept = rx_valid & ~ready;

    // Ready flag: set on capture, cleared by a data read
    always_ff @(posedge clk) begin
        if (!rst_n)         ready <= 1'b0;
        else if (accept)    ready <= 1'b1;
        else if (data_read) ready <= 1'b0;
    end

    // Holding register: loads only on an accepted arrival
    always_ff @(posedge clk) begin
        if (!rst_n)      char_q <= '0;
        else if (accept) char_q <= rx_char;
    end

    // R3: an accepted arrival is captured and flagged
    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ready) |=> (ready && char_q == $past(rx_char)));

    // R4: a waiting character survives further arrivals
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && rx_valid) |=> $stable(char_q));

    // R5: a read with no accepted arrival leaves the flag low
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_read && !(rx_valid && !ready)) |=> !ready);

endmodule

// File: rtl/cio_disp_port.sv
// Module: display output register with ready flag.
// A write is accepted only while the display is ready. Acceptance
// drops the flag and drives a one-cycle load pulse with the character.
// A done pulse raises the flag again.
// Assumes disp_done pulses once per loaded character.
module cio_disp_port #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              done,
    output logic              ready,
    output logic              load,
    output logic [CHAR_W-1:0] load_char
);

    logic take;

    // A write counts only while the display can accept it
    assign take = wr_strobe & ready;

    // Ready flag: starts high, drops on acceptance, rises on done
    always_ff @(posedge clk) begin
        if (!rst_n)    ready <= 1'b1;
        else if (take) ready <= 1'b0;
        else if (done) ready <= 1'b1;
    end

    // Load pulse: one cycle after each accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) load <= 1'b0;
        else        load <= take;
    end

    // Character register toward the display
    always_ff @(posedge clk) begin
        if (!rst_n)    load_char <= '0;
        else if (take) load_char <= wr_char;
    end

    // R7: a load pulse always finds the flag dropped
    p_load_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !ready);

    // R8: a write while busy yields no load pulse
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && !ready) |=> (!load && $stable(load_char)));

    // R9: done while busy restores the flag
    p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ready) |=> ready);

endmodule

// File: rtl/char_io_regfile.sv
// Module: top of the keyboard/display register window.
// Decodes the bus address, routes strobes to the two device ports and
// steers the read data between memory and the device registers.
// Assumes rd_data is sampled combinationally by the bus in the same
// cycle as rd_en, and that side effects take effect at the next edge.
module char_io_regfile
    import char_io_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter int                DATA_W  = 16,
    parameter int                CHAR_W  = 8,
    parameter logic [ADDR_W-1:0] KSTAT_A = 16'hFE00,
    parameter logic [ADDR_W-1:0] KDATA_A = 16'hFE02,
    parameter logic [ADDR_W-1:0] DSTAT_A = 16'hFE04,
    parameter logic [ADDR_W-1:0] DDATA_A = 16'hFE06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_sel,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              disp_done,
    output logic              disp_load,
    output logic [CHAR_W-1:0] disp_char
);

    localparam int PAD_W = DATA_W - CHAR_W;
    localparam int LOW_W = DATA_W - 1;

    cio_reg_e          reg_sel;
    logic              kbd_ready;
    logic [CHAR_W-1:0] kbd_char;
    logic              dsp_ready;
    logic              kbd_data_read;
    logic              dsp_data_write;
    logic              unused_wr_hi;

    // Only the character byte of a write is stored anywhere
    assign unused_wr_hi = ^wr_data[DATA_W-1:CHAR_W];

    cio_addr_decode #(
        .ADDR_W (ADDR_W),
        .KSTAT_A(KSTAT_A),
        .KDATA_A(KDATA_A),
        .DSTAT_A(DSTAT_A),
        .DDATA_A(DDATA_A)
    ) u_dec (
        .addr   (addr),
        .reg_sel(reg_sel),
        .mem_sel(mem_sel)
    );

    // Strobes qualified by the decoded register
    assign kbd_data_read  = rd_en & (reg_sel == REG_KDATA);
    assign dsp_data_write = wr_en & (reg_sel == REG_DDATA);

    cio_kbd_port #(.CHAR_W(CHAR_W)) u_kbd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_char  (rx_char),
        .data_read(kbd_data_read),
        .ready    (kbd_ready),
        .char_q   (kbd_char)
    );

    cio_disp_port #(.CHAR_W(CHAR_W)) u_dsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_strobe(dsp_data_write),
        .wr_char  (wr_data[CHAR_W-1:0]),
        .done     (disp_done),
        .ready    (dsp_ready),
        .load     (disp_load),
        .load_char(disp_char)
    );

    // Read steering between memory and the device registers
    always_comb begin
        unique case (reg_sel)
            REG_KSTAT: rd_data = {kbd_ready, {LOW_W{1'b0}}};
            REG_KDATA: rd_data = {{PAD_W{1'b0}}, kbd_char};
            REG_DSTAT: rd_data = {dsp_ready, {LOW_W{1'b0}}};
            REG_DDATA: rd_data = '0;
            default:   rd_data = mem_rdata;
        endcase
    end

    // R1: memory data is passed through whenever memory is selected
    p_mem_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> (rd_data == mem_rdata));

endmodule

// File: tb/tb_char_io_regfile.sv
// Bench: behavioural reference model compared on every clock, with
// directed scenarios followed by random traffic.
module tb_char_io_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] mem_rdata = 16'h0000;
    logic [15:0] rd_data;
    logic        mem_sel;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_char = 8'h00;
    logic        disp_done = 1'b0;
    logic        disp_load;
    logic [7:0]  disp_char;

    int total = 0;
    int bad = 0;
    bit started = 0;
    bit finished = 0;

    // reference model state
    bit       m_kr = 0;
    bit [7:0] m_kc = 0;
    bit       m_dr = 1;
    bit       m_dl = 0;
    bit [7:0] m_dc = 0;

    char_io_regfile dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .mem_rdata(mem_rdata), .rd_data(rd_data),
        .mem_sel(mem_sel), .rx_valid(rx_valid), .rx_char(rx_char),
        .disp_done(disp_done), .disp_load(disp_load), .disp_char(disp_char)
    );

    always #4 clk = ~clk;

    always @(posedge clk) started <= 1'b1;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // model compare then next-state step, away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            int kind;
            logic [15:0] exp_rd;
            string tag;
            kind = (addr == 16'hFE00) ? 1 : (addr == 16'hFE02) ? 2 :
                   (addr == 16'hFE04) ? 3 : (addr == 16'hFE06) ? 4 : 0;
            case (kind)
                1: begin exp_rd = {m_kr, 15'd0}; tag = "R3"; end
                2: begin exp_rd = {8'd0, m_kc};  tag = "R2"; end
                3: begin exp_rd = {m_dr, 15'd0}; tag = "R6"; end
                4: begin exp_rd = 16'd0;         tag = "R10"; end
                default: begin exp_rd = mem_rdata; tag = "R1"; end
            endcase
            chk("R1 mem_sel", {15'd0, mem_sel}, {15'd0, (kind == 0)});
            chk({tag, " rd_data"}, rd_data, exp_rd);
            chk("R7 disp_load", {15'd0, disp_load}, {15'd0, m_dl});
            chk("R8 disp_char", {8'd0, disp_char}, {8'd0, m_dc});
            if (!rst_n) begin
                m_kr = 0; m_kc = 0; m_dr = 1; m_dl = 0; m_dc = 0;
            end else begin
                if (rx_valid && !m_kr) begin
                    m_kr = 1; m_kc = rx_char;
                end else if (rd_en && kind == 2) begin
                    m_kr = 0;
                end
                if (wr_en && kind == 4 && m_dr) begin
                    m_dr = 0; m_dl = 1; m_dc = wr_data[7:0];
                end else begin
                    m_dl = 0;
                    if (disp_done) m_dr = 1;
                end
            end
        end
    end

    // one bus cycle of stimulus, driven just after the edge
    task automatic cyc(input bit r, input bit w, input logic [15:0] a, input logic [15:0] d,
                       input bit rv, input logic [7:0] rc, input bit dn);
        @(posedge clk);
        #2;
        rd_en = r; wr_en = w; addr = a; wr_data = d;
        rx_valid = rv; rx_char = rc; disp_done = dn;
        mem_rdata = 16'($urandom);
    endtask

    task automatic idle();
        cyc(0, 0, 16'h0100, 16'h0, 0, 8'h0, 0);
    endtask

    // directed read-back check in the current cycle
    task automatic peek(input string req, input logic [15:0] a, input logic [15:0] exp);
        cyc(0, 0, a, 16'h0, 0, 8'h0, 0);
        #1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        repeat (3) idle();
        cyc(0, 0, 16'h0100, 16'h0, 0, 8'h0, 0);
        rst_n = 1'b1;
        idle();
        peek("R6 reset kbd flag", 16'hFE00, 16'h0000);
        peek("R6 reset disp flag", 16'hFE04, 16'h8000);
        // R1: ordinary and near-miss addresses go to memory
        cyc(1, 0, 16'h1234, 16'h0, 0, 8'h0, 0); #1; chk("R1 mem data", rd_data, mem_rdata);
        cyc(1, 0, 16'hFE08, 16'h0, 0, 8'h0, 0); #1; chk("R1 near addr", {15'd0, mem_sel}, 16'd1);
        cyc(1, 0, 16'hFE01, 16'h0, 0, 8'h0, 0); #1; chk("R1 odd addr", {15'd0, mem_sel}, 16'd1);
        // R3: arrival sets flag
        cyc(0, 0, 16'h0, 16'h0, 1, 8'h41, 0);
        peek("R3 flag set", 16'hFE00, 16'h8000);
        // R2: data read, upper byte zero; R5 clears
        cyc(1, 0, 16'hFE02, 16'h0, 0, 8'h0, 0); #1; chk("R2 data", rd_data, 16'h0041);
        peek("R5 flag cleared", 16'hFE00, 16'h0000);
        // R4: second arrival while full is dropped
        cyc(0, 0, 16'h0, 16'h0, 1, 8'h42, 0);
        cyc(0, 0, 16'h0, 16'h0, 1, 8'h43, 0);
        peek("R4 held char", 16'hFE02, 16'h0042);
        cyc(1, 0, 16'hFE02, 16'h0, 0, 8'h0, 0);
        // R5: read and arrival together with flag low
        cyc(1, 0, 16'hFE02, 16'h0, 1, 8'h44, 0);
        peek("R5 same-cycle accept", 16'hFE00, 16'h8000);
        // R10: status and keyboard data writes do nothing
        cyc(0, 1, 16'hFE00, 16'h0000, 0, 8'h0, 0);
        cyc(0, 1, 16'hFE02, 16'hFFFF, 0, 8'h0, 0);
        peek("R10 kstat write", 16'hFE00, 16'h8000);
        peek("R10 kdata write", 16'hFE02, 16'h0044);
        // R7: accepted display write
        cyc(0, 1, 16'hFE06, 16'h1261, 0, 8'h0, 0);
        cyc(0, 0, 16'hFE04, 16'h0, 0, 8'h0, 0); #1;
        chk("R7 load pulse", {15'd0, disp_load}, 16'd1);
        chk("R7 load char", {8'd0, disp_char}, 16'h0061);
        chk("R7 flag low", rd_data, 16'h0000);
        // R8: write while busy ignored
        cyc(0, 1, 16'hFE06, 16'h0062, 0, 8'h0, 0);
        cyc(0, 0, 16'hFE04, 16'h0, 0, 8'h0, 0); #1;
        chk("R8 no pulse", {15'd0, disp_load}, 16'd0);
        chk("R8 char kept", {8'd0, disp_char}, 16'h0061);
        // R9: ignored write together with done
        cyc(0, 1, 16'hFE06, 16'h0063, 0, 8'h0, 1);
        peek("R9 flag back", 16'hFE04, 16'h8000);
        #1; chk("R9 char kept", {8'd0, disp_char}, 16'h0061);
        // R10: display status write has no effect
        cyc(0, 1, 16'hFE04, 16'h0000, 0, 8'h0, 0);
        peek("R10 dstat write", 16'hFE04, 16'h8000);
        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            int s;
            s = $urandom_range(0, 4);
            a = (s == 0) ? 16'($urandom) : (16'hFE00 + 16'(2 * (s - 1)));
            cyc($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, a, 16'($urandom),
                $urandom_range(0, 3) == 0, 8'($urandom), $urandom_range(0, 4) == 0);
        end
        idle();
        idle();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule